// File: doc/BRIEF.md
# UART Interrupt Aggregator

This block gathers the four interrupt causes of one serial channel into a single interrupt line. A set of sticky source bits records receive, error, transmit and modem events. A per-bit enable mask decides which recorded sources reach the pending view. The output line is high while any pending bit is set. Software clears source bits by writing ones, either through the source view or through the pending view. The mask is loaded with a plain write.

The transmit source has a second, level-driven origin. While the transmit queue is enabled, the block compares the queue fill count against a trigger level on every cycle and keeps the transmit source asserted while the fill is at or below that level. The trigger level is a 3-bit configuration field multiplied by a factor that depends on the channel number. The channel number is fixed when the block is elaborated.

Top module: `uart_irq_agg`

## Requirements
- R1: After reset the source bits and the mask are all zero, so the pending bits are zero and `irq` is low.
- R2: A one-cycle pulse on `rx_evt`, `err_evt` or `modem_evt` sets source bit 0, 1 or 3 respectively, visible on `src_pend` the cycle after the pulse; the bit stays set until cleared.
- R3: `int_pend` equals `src_pend` AND NOT `int_mask`, and `irq` is high exactly when `int_pend` is nonzero.
- R4: A write with `cfg_sel` = 2'b01 clears every source bit (and therefore every pending bit) whose `cfg_wdata` bit is one, and leaves the others unchanged.
- R5: A write with `cfg_sel` = 2'b00 clears every source bit whose `cfg_wdata` bit is one, and leaves the others unchanged.
- R6: A write with `cfg_sel` = 2'b10 loads `cfg_wdata` into `int_mask`; `int_pend` and `irq` reflect the new mask from the next cycle.
- R7: A write with `cfg_sel` = 2'b11 changes neither the source bits nor the mask.
- R8: A set event and a clear of the same bit in the same cycle leave the bit set.
- R9: While `txq_en` is high, source bit 2 is set on every cycle in which `txq_fill` <= `txq_trig` x F, where F is 32 for channel 0, 8 for channels 1 and 4, 2 for channels 2 and 3, and 0 for any other channel.
- R10: While `txq_en` is low, the fill comparison sets no source bit.
- R11: A pulse on `thr_wr` sets source bit 2 whatever the state of `txq_en`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Write target: 00 source clear, 01 pending clear, 10 mask load, 11 none |
| cfg_wdata | input | 4 | Write data, one bit per source |
| rx_evt | input | 1 | Receive event pulse |
| err_evt | input | 1 | Error event pulse |
| modem_evt | input | 1 | Modem event pulse |
| thr_wr | input | 1 | Transmit holding register write pulse |
| txq_en | input | 1 | Transmit queue enabled |
| txq_trig | input | TRIG_W | Transmit trigger field |
| txq_fill | input | CNT_W | Transmit queue fill count |
| src_pend | output | 4 | Source bits: 0 receive, 1 error, 2 transmit, 3 modem |
| int_mask | output | 4 | Mask, one disables the source |
| int_pend | output | 4 | Unmasked source bits |
| irq | output | 1 | Interrupt line |

## Verification
The pending and line outputs are swept over all sixteen masks with every source set. This separates a correct AND-NOT from a plain AND, an inverted mask or a line that ignores one bit. Clears through both write views are applied with all sixteen data patterns on a full source set, which exposes a wrong bit order or a cleared neighbour. The transmit comparison is swept over every trigger field and every fill count on six channel variants at once. This pins down the factor, the inclusive boundary and the zero-level fallback. Same-cycle set and clear, the unused write code and the disabled queue are each tried in isolation.

// File: rtl/uirq_pkg.sv
package uirq_pkg;

   localparam int unsigned UIRQ_NSRC = 4;

   localparam int unsigned SRC_RX    = 0;
   localparam int unsigned SRC_ERR   = 1;
   localparam int unsigned SRC_TX    = 2;
   localparam int unsigned SRC_MODEM = 3;

   typedef enum logic [1:0] {
      WSEL_SRC_CLR  = 2'b00,
      WSEL_PEND_CLR = 2'b01,
      WSEL_MASK     = 2'b10,
      WSEL_NONE     = 2'b11
   } uirq_wsel_e;

   // scaling of the transmit trigger field per channel number
   function automatic int unsigned uirq_tx_factor(input int unsigned ch);
      case (ch)
         0:       return 32;
         1, 4:    return 8;
         2, 3:    return 2;
         default: return 0;
      endcase
   endfunction

endpackage

// File: rtl/uirq_tx_level.sv
module uirq_tx_level #(
   parameter int unsigned CHANNEL = 0,
   parameter int unsigned TRIG_W  = 3,
   parameter int unsigned CNT_W   = 8
) (
   input  logic              txq_en,
   input  logic [TRIG_W-1:0] txq_trig,
   input  logic [CNT_W-1:0]  txq_fill,
   output logic              tx_req
);
   import uirq_pkg::*;

   localparam int unsigned FACTOR = uirq_tx_factor(CHANNEL);
   localparam int unsigned LVL_W  = TRIG_W + 6;
   localparam int unsigned CMP_W  = (LVL_W > CNT_W) ? LVL_W : CNT_W;

   initial begin
      assert (TRIG_W >= 1 && TRIG_W <= 8) else $error("TRIG_W out of range");
      assert (CNT_W >= 1 && CNT_W <= 16) else $error("CNT_W out of range");
   end

   logic [LVL_W-1:0] level;

   generate
      if (FACTOR == 0) begin : g_no_level
         assign level = '0;
      end else begin : g_scaled
         assign level = LVL_W'(txq_trig) * LVL_W'(FACTOR);
      end
   endgenerate

   assign tx_req = txq_en && (CMP_W'(txq_fill) <= CMP_W'(level));

endmodule

// File: rtl/uirq_src_bank.sv
module uirq_src_bank #(
   parameter int unsigned NBIT = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NBIT-1:0] set_vec,
   input  logic [NBIT-1:0] clr_vec,
   output logic [NBIT-1:0] q
);
   initial begin
      assert (NBIT >= 1) else $error("NBIT must be positive");
   end

   generate
      for (genvar i = 0; i < NBIT; i++) begin : g_bit
         logic bit_q;
         // a set outranks a clear landing in the same cycle
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          bit_q <= 1'b0;
            else if (set_vec[i]) bit_q <= 1'b1;
            else if (clr_vec[i]) bit_q <= 1'b0;
         end
         assign q[i] = bit_q;
      end
   endgenerate

endmodule

// File: rtl/uart_irq_agg.sv
module uart_irq_agg #(
   parameter int unsigned CHANNEL = 0,
   parameter int unsigned TRIG_W  = 3,
   parameter int unsigned CNT_W   = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic [1:0]        cfg_sel,
   input  logic [3:0]        cfg_wdata,
   input  logic              rx_evt,
   input  logic              err_evt,
   input  logic              modem_evt,
   input  logic              thr_wr,
   input  logic              txq_en,
   input  logic [TRIG_W-1:0] txq_trig,
   input  logic [CNT_W-1:0]  txq_fill,
   output logic [3:0]        src_pend,
   output logic [3:0]        int_mask,
   output logic [3:0]        int_pend,
   output logic              irq
);
   import uirq_pkg::*;

   localparam int unsigned NS = UIRQ_NSRC;

   uirq_wsel_e      wsel;
   logic            tx_req;
   logic [NS-1:0]   set_vec;
   logic [NS-1:0]   clr_vec;
   logic [NS-1:0]   mask_q;

   assign wsel = uirq_wsel_e'(cfg_sel);

   uirq_tx_level #(
      .CHANNEL (CHANNEL),
      .TRIG_W  (TRIG_W),
      .CNT_W   (CNT_W)
   ) u_tx_level (
      .txq_en   (txq_en),
      .txq_trig (txq_trig),
      .txq_fill (txq_fill),
      .tx_req   (tx_req)
   );

   always_comb begin
      set_vec             = '0;
      set_vec[SRC_RX]     = rx_evt;
      set_vec[SRC_ERR]    = err_evt;
      set_vec[SRC_TX]     = thr_wr | tx_req;
      set_vec[SRC_MODEM]  = modem_evt;
   end

   // both clear views act on the source bits; pending is derived from them
   always_comb begin
      clr_vec = '0;
      if (cfg_wr && (wsel == WSEL_SRC_CLR || wsel == WSEL_PEND_CLR))
         clr_vec = cfg_wdata;
   end

   uirq_src_bank #(
      .NBIT (NS)
   ) u_src_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_vec (set_vec),
      .clr_vec (clr_vec),
      .q       (src_pend)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            mask_q <= '0;
      else if (cfg_wr && wsel == WSEL_MASK)  mask_q <= cfg_wdata;
   end

   assign int_mask = mask_q;
   assign int_pend = src_pend & ~mask_q;
   assign irq      = |int_pend;

endmodule

// File: rtl/uirq_chk.sv
module uirq_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       cfg_wr,
   input logic [1:0] cfg_sel,
   input logic [3:0] cfg_wdata,
   input logic       rx_evt,
   input logic       err_evt,
   input logic       modem_evt,
   input logic       thr_wr,
   input logic [3:0] src_pend,
   input logic [3:0] int_mask,
   input logic       irq
);

   a_r2_rx_sets: assert property (@(posedge clk) disable iff (!rst_n)
      rx_evt |=> src_pend[0]);

   a_r3_line_level: assert property (@(posedge clk) disable iff (!rst_n)
      irq == ((src_pend & ~int_mask) != 4'd0));

   a_r4_pend_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr && cfg_sel == 2'b01 && cfg_wdata[0] && !rx_evt) |=> !src_pend[0]);

   a_r5_src_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr && cfg_sel == 2'b00 && cfg_wdata[3] && !modem_evt) |=> !src_pend[3]);

   a_r6_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr && cfg_sel == 2'b10) |=> (int_mask == $past(cfg_wdata)));

   a_r7_none_mask: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr && cfg_sel == 2'b11) |=> $stable(int_mask));

   a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (err_evt && cfg_wr && !cfg_sel[1] && cfg_wdata[1]) |=> src_pend[1]);

   a_r11_thr_sets: assert property (@(posedge clk) disable iff (!rst_n)
      thr_wr |=> src_pend[2]);

endmodule

bind uart_irq_agg uirq_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cfg_wr    (cfg_wr),
   .cfg_sel   (cfg_sel),
   .cfg_wdata (cfg_wdata),
   .rx_evt    (rx_evt),
   .err_evt   (err_evt),
   .modem_evt (modem_evt),
   .thr_wr    (thr_wr),
   .src_pend  (src_pend),
   .int_mask  (int_mask),
   .irq       (irq)
);

// File: tb/test_uart_irq_agg.sv
`timescale 1ns/1ps
module test_uart_irq_agg;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_wr = 1'b0;
   logic [1:0] cfg_sel = 2'b11;
   logic [3:0] cfg_wdata = 4'd0;
   logic       rx_evt = 1'b0, err_evt = 1'b0, modem_evt = 1'b0, thr_wr = 1'b0;
   logic       txq_en = 1'b0;
   logic [2:0] txq_trig = 3'd0;
   logic [7:0] txq_fill = 8'd0;

   logic [3:0] src_pend, int_mask, int_pend;
   logic       irq;

   logic [3:0] x_src  [1:5];
   logic [3:0] x_mask [1:5];
   logic [3:0] x_pend [1:5];
   logic       x_irq  [1:5];

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   uart_irq_agg #(.CHANNEL(0), .TRIG_W(3), .CNT_W(8)) i_uart_irq_agg (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .rx_evt(rx_evt), .err_evt(err_evt),
      .modem_evt(modem_evt), .thr_wr(thr_wr), .txq_en(txq_en),
      .txq_trig(txq_trig), .txq_fill(txq_fill), .src_pend(src_pend),
      .int_mask(int_mask), .int_pend(int_pend), .irq(irq));

   generate
      for (genvar c = 1; c <= 5; c++) begin : g_ch
         uart_irq_agg #(.CHANNEL(c), .TRIG_W(3), .CNT_W(8)) i_ch (
            .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
            .cfg_wdata(cfg_wdata), .rx_evt(rx_evt), .err_evt(err_evt),
            .modem_evt(modem_evt), .thr_wr(thr_wr), .txq_en(txq_en),
            .txq_trig(txq_trig), .txq_fill(txq_fill), .src_pend(x_src[c]),
            .int_mask(x_mask[c]), .int_pend(x_pend[c]), .irq(x_irq[c]));
      end
   endgenerate

   function automatic int exp_factor(input int ch);
      if (ch == 0) return 32;
      if (ch == 1 || ch == 4) return 8;
      if (ch == 2 || ch == 3) return 2;
      return 0;
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", req, act, exp);
      end
   endtask

   // one clock: inputs set by caller take effect at the posedge, then pulses drop
   task automatic tick();
      @(negedge clk);
      cfg_wr = 1'b0; rx_evt = 1'b0; err_evt = 1'b0; modem_evt = 1'b0; thr_wr = 1'b0;
   endtask

   task automatic wr(input logic [1:0] sel, input logic [3:0] d);
      cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = d;
      tick();
   endtask

   task automatic set_all();
      rx_evt = 1'b1; err_evt = 1'b1; thr_wr = 1'b1; modem_evt = 1'b1;
      tick();
   endtask

   task automatic summary();
      $display("  test done: total=%0d bad=%0d", total, bad);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         bad++;
         total++;
         $display("FAIL watchdog act=hung exp=done");
         summary();
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 src", src_pend, 0);
      chk("R1 mask", int_mask, 0);
      chk("R1 irq", irq, 0);

      // R2 individual event bit positions
      rx_evt = 1'b1; tick(); chk("R2 rx bit0", src_pend, 4'b0001);
      tick();                chk("R2 rx sticky", src_pend, 4'b0001);
      wr(2'b00, 4'hF);
      err_evt = 1'b1; tick(); chk("R2 err bit1", src_pend, 4'b0010);
      wr(2'b00, 4'hF);
      modem_evt = 1'b1; tick(); chk("R2 modem bit3", src_pend, 4'b1000);
      wr(2'b00, 4'hF);
      // R11 transmit holding write with queue disabled
      thr_wr = 1'b1; tick(); chk("R11 thr bit2", src_pend, 4'b0100);
      wr(2'b00, 4'hF);
      chk("R5 all cleared", src_pend, 0);

      // R3 / R6 mask sweep over a full source set
      set_all();
      for (int m = 0; m < 16; m++) begin
         wr(2'b10, 4'(m));
         chk("R6 mask", int_mask, m);
         chk("R3 pend", int_pend, 4'hF & ~m);
         chk("R3 irq", irq, (m != 15) ? 1 : 0);
      end
      wr(2'b10, 4'h0);

      // R4 pending-view clears
      for (int d = 0; d < 16; d++) begin
         set_all();
         wr(2'b01, 4'(d));
         chk("R4 src", src_pend, 4'hF & ~d);
         chk("R4 pend", int_pend, 4'hF & ~d);
         chk("R4 irq", irq, (d != 15) ? 1 : 0);
      end

      // R5 source-view clears
      for (int d = 0; d < 16; d++) begin
         set_all();
         wr(2'b00, 4'(d));
         chk("R5 src", src_pend, 4'hF & ~d);
      end

      // R7 unused write code
      set_all();
      wr(2'b10, 4'b0101);
      wr(2'b11, 4'hF);
      chk("R7 src kept", src_pend, 4'hF);
      chk("R7 mask kept", int_mask, 4'b0101);
      chk("R7 pend", int_pend, 4'b1010);
      wr(2'b10, 4'h0);

      // R8 set wins over same-cycle clear, both views
      wr(2'b00, 4'hF);
      err_evt = 1'b1; wr(2'b00, 4'hF);
      chk("R8 src view", src_pend, 4'b0010);
      rx_evt = 1'b1; wr(2'b01, 4'hF);
      chk("R8 pend view", src_pend, 4'b0001);
      wr(2'b00, 4'hF);

      // R10 disabled queue: fill 0 under field 0 would trigger if enabled
      txq_en = 1'b0; txq_trig = 3'd0; txq_fill = 8'd0;
      wr(2'b00, 4'hF);
      chk("R10 ch0", src_pend, 0);
      for (int c = 1; c <= 5; c++) chk("R10 chN", x_src[c], 0);

      // R9 exhaustive trigger sweep on six channel variants
      txq_en = 1'b1;
      for (int f = 0; f < 8; f++) begin
         for (int n = 0; n < 256; n++) begin
            txq_trig = 3'(f); txq_fill = 8'(n);
            wr(2'b00, 4'b0100);
            chk("R9 ch0", src_pend[2], (n <= f * exp_factor(0)) ? 1 : 0);
            for (int c = 1; c <= 5; c++)
               chk("R9 chN", x_src[c][2], (n <= f * exp_factor(c)) ? 1 : 0);
         end
      end
      txq_en = 1'b0;
      tick();

      finished = 1'b1;
      summary();
      $finish;
   end

endmodule